// File: doc/BRIEF.md
# Paged Register Access Slave over SPI

This block is a serial slave that lets a host read and write a register file organised as pages of 64 sixteen-bit locations. The host opens a transaction by pulling the active-low select line down, sends a 16-bit command word and then clocks any number of 16-bit data words. The command word sets the direction, the page and the starting location. Each data word after it uses the current location, and the location pointer then steps forward. The pointer never wraps into the next page.

The serial side works in clock mode 1 (polarity 0, phase 1). The serial clock idles low. Both sides launch a bit on the rising edge and capture it on the falling edge, most significant bit first. The serial pins are sampled by a faster system clock, which also runs the command decoder, the pointer and a single-port register array of four implemented pages. The array is written so that it can map onto block RAM. Read data for the next word is fetched during the half serial period after a word's last falling edge.

Top module: `spi_paged_regs`

## Requirements
- R1: After a synchronous reset, `miso_oe` and `miso` are both 0.
- R2: Bits move most significant first. The slave shifts out each bit on a serial-clock rising edge, and the host captures it at the next falling edge.
- R3: A command word decodes as follows: bit 15 is 1 for read and 0 for write, bits 14:11 give the page and bits 10:5 give the start location. For example, 0x0800 is a write to page 1 at location 0 and 0x8000 is a read of page 0 from location 0.
- R4: In a write burst, data word k is stored at start location + k within the selected page.
- R5: In a read burst, data word k returns the contents of start location + k. Every word requested after location 63 of the page returns 0xFFFF.
- R6: Write data words that fall past location 63 are discarded and never wrap to the start of the page or into another page.
- R7: Page codes 4 to 15 are reserved. Writes to them change no stored register, and reads from them return 0xFFFF.
- R8: Only the first complete word after a falling edge of select is taken as a command. Later words in the same low period are data, even if their bit pattern looks like a command.
- R9: A word cut short by select rising performs no write, and the next falling edge of select restarts word alignment.
- R10: `miso_oe` is 0 while select is high and 1 while it is low. During the command word, `miso` shifts out zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host, idles low |
| ss_n | input | 1 | Active-low select from the host |
| mosi | input | 1 | Serial data from host to slave |
| miso | output | 1 | Serial data from slave to host |
| miso_oe | output | 1 | Output enable for the `miso` pad driver |

## Verification
The assertions rely on the serial clock being slow against the system clock. Each half serial period must last at least five system cycles, so that a fetched read word is loaded before the next rising edge is detected. They also rely on select not changing in the same cycle as a serial-clock edge. The bench keeps every half period at six system cycles. It moves select only while the serial clock is low and at least six cycles away from any edge, so the stimulus stays inside those limits.

// File: rtl/spi_paged_pkg.sv
package spi_paged_pkg;

  // Command word layout; bit positions are what the host encodes.
  localparam int CMD_W        = 16;
  localparam int CMD_DIR_BIT  = 15;
  localparam int CMD_PAGE_LSB = 11;
  localparam int CMD_PAGE_W   = 4;
  localparam int CMD_LOC_LSB  = 5;
  localparam int CMD_LOC_W    = 6;
  localparam int CMD_RSVD_W   = 5;

  typedef struct packed {
    logic                  rd;
    logic [CMD_PAGE_W-1:0] page;
    logic [CMD_LOC_W-1:0]  loc;
    logic [CMD_RSVD_W-1:0] rsvd;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [CMD_W-1:0] w);
    cmd_t c;
    c.rd   = w[CMD_DIR_BIT];
    c.page = w[CMD_PAGE_LSB +: CMD_PAGE_W];
    c.loc  = w[CMD_LOC_LSB +: CMD_LOC_W];
    c.rsvd = w[CMD_RSVD_W-1:0];
    return c;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic ss_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic ss_fall,
  output logic ss_high,
  output logic mosi_s
);

  logic [STAGES-1:0] sclk_pipe, ss_pipe, mosi_pipe;
  logic              sclk_prev, ss_prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          sclk_pipe <= '0;
          ss_pipe   <= '1;
          mosi_pipe <= '0;
        end else begin
          sclk_pipe <= sclk;
          ss_pipe   <= ss_n;
          mosi_pipe <= mosi;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          sclk_pipe <= '0;
          ss_pipe   <= '1;
          mosi_pipe <= '0;
        end else begin
          sclk_pipe <= {sclk_pipe[STAGES-2:0], sclk};
          ss_pipe   <= {ss_pipe[STAGES-2:0], ss_n};
          mosi_pipe <= {mosi_pipe[STAGES-2:0], mosi};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      ss_prev   <= 1'b1;
    end else begin
      sclk_prev <= sclk_pipe[STAGES-1];
      ss_prev   <= ss_pipe[STAGES-1];
    end
  end

  assign sclk_rise = sclk_pipe[STAGES-1] & ~sclk_prev;
  assign sclk_fall = ~sclk_pipe[STAGES-1] & sclk_prev;
  assign ss_fall   = ~ss_pipe[STAGES-1] & ss_prev;
  assign ss_high   = ss_pipe[STAGES-1];
  assign mosi_s    = mosi_pipe[STAGES-1];

endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              ss_fall,
  input  logic              ss_high,
  input  logic              mosi_s,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_word,
  output logic              word_done,
  output logic              word_is_cmd,
  output logic [WORD_W-1:0] rx_word,
  output logic              miso,
  output logic              miso_oe
);

  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  bit_cnt_q;
  logic [WORD_W-1:0] rx_sr_q, tx_sr_q;
  logic              first_q;

  // Receive side: capture on falling edges, frame words of WORD_W bits.
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt_q   <= '0;
      rx_sr_q     <= '0;
      first_q     <= 1'b0;
      word_done   <= 1'b0;
      word_is_cmd <= 1'b0;
      rx_word     <= '0;
    end else begin
      word_done <= 1'b0;
      if (ss_high || ss_fall) begin
        bit_cnt_q <= '0;
        first_q   <= ss_fall;
      end else if (sclk_fall) begin
        rx_sr_q   <= {rx_sr_q[WORD_W-2:0], mosi_s};
        bit_cnt_q <= (bit_cnt_q == LAST_BIT) ? '0 : bit_cnt_q + 1'b1;
        if (bit_cnt_q == LAST_BIT) begin
          word_done   <= 1'b1;
          word_is_cmd <= first_q;
          rx_word     <= {rx_sr_q[WORD_W-2:0], mosi_s};
          first_q     <= 1'b0;
        end
      end
    end
  end

  // Transmit side: launch on rising edges, zeros until a word is loaded.
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr_q <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= ~ss_high;
      if (ss_high || ss_fall) begin
        tx_sr_q <= '0;
        miso    <= 1'b0;
      end else if (tx_load) begin
        tx_sr_q <= tx_word;
      end else if (sclk_rise) begin
        miso    <= tx_sr_q[WORD_W-1];
        tx_sr_q <= {tx_sr_q[WORD_W-2:0], 1'b0};
      end
    end
  end

  assert_cnt_clear_R9: assert property (@(posedge clk) disable iff (rst)
    ss_fall |=> (bit_cnt_q == '0));

  assert_tx_clear_R10: assert property (@(posedge clk) disable iff (rst)
    ss_fall |=> (tx_sr_q == '0) && !miso);

  assert_idle_oe_R10: assert property (@(posedge clk) disable iff (rst)
    ss_high |=> !miso_oe);

endmodule

// File: rtl/paged_access_ctrl.sv
module paged_access_ctrl
  import spi_paged_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int NUM_PAGES = 4,
  localparam int LOC_W    = CMD_LOC_W,
  localparam int PSEL_W   = $clog2(NUM_PAGES),
  localparam int RF_AW    = PSEL_W + LOC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_high,
  input  logic              sclk_rise,
  input  logic              word_done,
  input  logic              word_is_cmd,
  input  logic [WORD_W-1:0] rx_word,
  output logic [RF_AW-1:0]  rf_addr,
  output logic [WORD_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              rf_re,
  input  logic [WORD_W-1:0] rf_rdata,
  output logic              tx_load,
  output logic [WORD_W-1:0] tx_word
);

  cmd_t                  cmd;
  logic                  cmd_valid_q, rd_q;
  logic [CMD_PAGE_W-1:0] page_q, fetch_page;
  logic [LOC_W:0]        ptr_q, ptr_inc, fetch_ptr;
  logic                  page_ok, write_ok, do_write, do_fetch, fetch_oob;
  logic                  oob1_q, oob2_q, pend2_q;

  always_comb begin
    cmd        = decode_cmd(rx_word);
    ptr_inc    = ptr_q[LOC_W] ? ptr_q : ptr_q + (LOC_W+1)'(1);
    page_ok    = int'(page_q) < NUM_PAGES;
    write_ok   = page_ok && !ptr_q[LOC_W];
    do_write   = word_done && !word_is_cmd && cmd_valid_q && !rd_q;
    do_fetch   = word_done && (word_is_cmd ? cmd.rd : (cmd_valid_q && rd_q));
    fetch_page = word_is_cmd ? cmd.page : page_q;
    fetch_ptr  = word_is_cmd ? {1'b0, cmd.loc} : ptr_inc;
    fetch_oob  = (int'(fetch_page) >= NUM_PAGES) || fetch_ptr[LOC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid_q <= 1'b0;
      rd_q        <= 1'b0;
      page_q      <= '0;
      ptr_q       <= '0;
      rf_we       <= 1'b0;
      rf_re       <= 1'b0;
      rf_addr     <= '0;
      rf_wdata    <= '0;
      oob1_q      <= 1'b0;
      oob2_q      <= 1'b0;
      pend2_q     <= 1'b0;
    end else begin
      rf_we   <= 1'b0;
      rf_re   <= 1'b0;
      pend2_q <= rf_re;
      oob2_q  <= oob1_q;
      if (word_done) begin
        if (word_is_cmd) begin
          cmd_valid_q <= 1'b1;
          rd_q        <= cmd.rd;
          page_q      <= cmd.page;
          ptr_q       <= {1'b0, cmd.loc};
        end else if (cmd_valid_q) begin
          ptr_q <= ptr_inc;
        end
      end
      if (ss_high) cmd_valid_q <= 1'b0;
      if (do_write && write_ok) begin
        rf_we    <= 1'b1;
        rf_addr  <= {page_q[PSEL_W-1:0], ptr_q[LOC_W-1:0]};
        rf_wdata <= rx_word;
      end
      if (do_fetch) begin
        rf_re   <= 1'b1;
        rf_addr <= {fetch_page[PSEL_W-1:0], fetch_ptr[LOC_W-1:0]};
        oob1_q  <= fetch_oob;
      end
    end
  end

  assign tx_load = pend2_q;
  assign tx_word = oob2_q ? '1 : rf_rdata;

  assert_ptr_bound_R4: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= (LOC_W+1)'(2**LOC_W));

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (word_done && !word_is_cmd && cmd_valid_q && !ptr_q[LOC_W])
      |=> (ptr_q == $past(ptr_q) + (LOC_W+1)'(1)));

  assert_load_gap_R2: assert property (@(posedge clk) disable iff (rst)
    !(tx_load && sclk_rise));

  assert_we_not_re_R3: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> !rf_re);

endmodule

// File: rtl/paged_reg_array.sv
module paged_reg_array #(
  parameter int WORD_W = 16,
  parameter int AW     = 8,
  localparam int DEPTH = 2**AW
) (
  input  logic              clk,
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  logic              re,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

endmodule

// File: rtl/spi_paged_regs.sv
module spi_paged_regs #(
  parameter int WORD_W      = 16,
  parameter int NUM_PAGES   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int RF_AW      = $clog2(NUM_PAGES) + spi_paged_pkg::CMD_LOC_W
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic ss_n,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);

  logic              sclk_rise, sclk_fall, ss_fall, ss_high, mosi_s;
  logic              word_done, word_is_cmd, tx_load, rf_we, rf_re;
  logic [WORD_W-1:0] rx_word, tx_word, rf_wdata, rf_rdata;
  logic [RF_AW-1:0]  rf_addr;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .ss_fall(ss_fall),
    .ss_high(ss_high), .mosi_s(mosi_s)
  );

  spi_word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst(rst), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .ss_fall(ss_fall), .ss_high(ss_high), .mosi_s(mosi_s),
    .tx_load(tx_load), .tx_word(tx_word), .word_done(word_done),
    .word_is_cmd(word_is_cmd), .rx_word(rx_word), .miso(miso), .miso_oe(miso_oe)
  );

  paged_access_ctrl #(.WORD_W(WORD_W), .NUM_PAGES(NUM_PAGES)) u_ctrl (
    .clk(clk), .rst(rst), .ss_high(ss_high), .sclk_rise(sclk_rise),
    .word_done(word_done), .word_is_cmd(word_is_cmd), .rx_word(rx_word),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re),
    .rf_rdata(rf_rdata), .tx_load(tx_load), .tx_word(tx_word)
  );

  paged_reg_array #(.WORD_W(WORD_W), .AW(RF_AW)) u_regs (
    .clk(clk), .addr(rf_addr), .we(rf_we), .re(rf_re),
    .wdata(rf_wdata), .rdata(rf_rdata)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !miso_oe && !miso);

endmodule

// File: tb/spi_paged_regs_tb.sv
module spi_paged_regs_tb;

  localparam int HALF = 6;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, ss_n = 1'b1, mosi = 1'b0;
  wire  miso, miso_oe;
  int   n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  spi_paged_regs u_dut (
    .clk(clk), .rst(rst), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe)
  );

  function automatic logic [15:0] pat(input int p, input int a);
    return 16'((p * 'h1357) ^ (a * 'h0101) ^ 'hA5C3);
  endfunction

  function automatic logic [15:0] mk_cmd(input bit rd, input int p, input int a);
    return {rd, 4'(p), 6'(a), 5'b0};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel_on;
    ss_n = 1'b0;
    tick(HALF);
  endtask

  task automatic sel_off;
    tick(HALF);
    ss_n = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    for (int i = 15; i >= 16 - nbits; i--) begin
      sclk = 1'b1;
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      sclk = 1'b0;
      tick(HALF);
    end
  endtask

  task automatic put_cmd(input logic [15:0] c);
    logic [15:0] r;
    xfer(c, 16, r);
    check("R10 command-phase miso", r, 16'h0000);
  endtask

  task automatic put_data(input logic [15:0] d);
    logic [15:0] r;
    xfer(d, 16, r);
  endtask

  task automatic read_expect(input int p, input int a, input int n, input string tag);
    logic [15:0] r;
    sel_on;
    put_cmd(mk_cmd(1'b1, p, a));
    for (int k = 0; k < n; k++) begin
      xfer(16'h0000, 16, r);
      if (p > 3 || a + k > 63) check(tag, r, 16'hFFFF);
      else check(tag, r, pat(p, a + k));
    end
    sel_off;
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (no requirement) actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    tick(4);
    rst = 1'b0;
    tick(3);
    check("R1 reset miso_oe/miso", {14'b0, miso_oe, miso}, 16'h0000);

    // R3 R4: full-page write bursts (page 1 uses command 0x0800)
    for (int p = 0; p < 4; p++) begin
      sel_on;
      check("R10 oe while selected", {15'b0, miso_oe}, 16'h0001);
      put_cmd(mk_cmd(1'b0, p, 0));
      for (int a = 0; a < 64; a++) put_data(pat(p, a));
      sel_off;
      check("R10 oe idle", {15'b0, miso_oe}, 16'h0000);
    end

    // R2 R5: full-page read bursts plus one word past the end (page 0 uses 0x8000)
    for (int p = 0; p < 4; p++) read_expect(p, 0, 65, "R2/R5 read burst");
    read_expect(2, 60, 6, "R5 read from mid-page past end");

    // R6: write burst running off the end of a page
    sel_on;
    put_cmd(mk_cmd(1'b0, 2, 62));
    put_data(16'h1111);
    put_data(16'h2222);
    put_data(16'h3333);
    sel_off;
    sel_on;
    put_cmd(mk_cmd(1'b1, 2, 62));
    xfer(16'h0, 16, r); check("R6 loc 62", r, 16'h1111);
    xfer(16'h0, 16, r); check("R6 loc 63", r, 16'h2222);
    xfer(16'h0, 16, r); check("R6 past end", r, 16'hFFFF);
    sel_off;
    read_expect(2, 0, 1, "R6 no wrap to loc 0");
    read_expect(3, 0, 1, "R6 next page untouched");

    // R7: reserved page codes
    for (int p = 4; p < 16; p++) begin
      sel_on;
      put_cmd(mk_cmd(1'b0, p, 3));
      put_data(16'h1234);
      sel_off;
      read_expect(p, 3, 2, "R7 reserved page read");
    end
    for (int p = 0; p < 4; p++) read_expect(p, 3, 1, "R7 implemented pages untouched");

    // R8: command-like data words while select stays low
    sel_on;
    put_cmd(mk_cmd(1'b0, 0, 5));
    put_data(16'h8000);
    tick(3 * HALF);
    put_data(16'h0800);
    sel_off;
    sel_on;
    put_cmd(mk_cmd(1'b1, 0, 5));
    xfer(16'h0, 16, r); check("R8 data not command", r, 16'h8000);
    xfer(16'h0, 16, r); check("R8 second data word", r, 16'h0800);
    sel_off;

    // R9: partial word dropped, realignment after next select
    sel_on;
    put_cmd(mk_cmd(1'b0, 3, 10));
    xfer(16'hBEEF, 8, r);
    sel_off;
    read_expect(3, 10, 1, "R9 partial word no write");
    sel_on;
    put_cmd(mk_cmd(1'b0, 3, 11));
    xfer(16'hDEAD, 5, r);
    sel_off;
    read_expect(3, 10, 3, "R9 realigned read");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule